// File: doc/BRIEF.md
# AXI-Stream Packet Source

This block is a stream master that sends packets of a chosen length. A one-cycle request on `start_i` carries a length on `len_i`. The block then sends exactly that many beats on an AXI4-Stream style channel (`m_tvalid`, `m_tready`, `m_tdata`, `m_tlast`). It raises `m_tlast` on the final beat. The payload is a free-running count of every beat the sink has accepted since reset, and it continues across packet boundaries. The block is used to generate test traffic or framing inside a larger datapath. It feeds any sink that follows the valid/ready handshake, including sinks that apply backpressure at any time.

The three channel outputs live in a single register stage. That stage reloads only when the slot is empty or the current beat is being taken, so backpressure can never change an offered beat. Beat position is counted from accepted transfers alone. As a result, the end-of-packet marker cannot appear early when the sink stalls just before the end.

A small state machine sequences each packet:

- **IDLE**: nothing is offered.
- **STREAM**: a non-final beat is offered.
- **LAST**: the final beat is offered.

Its transitions are:

- **IDLE→STREAM**: a start with length of two or more.
- **IDLE→LAST**: a start with length one.
- **STREAM→STREAM**: a non-final beat is accepted and the next beat is not the final one.
- **STREAM→LAST**: the beat before the final one is accepted.
- **LAST→IDLE**: the final beat is accepted with no start.
- **LAST→STREAM / LAST→LAST**: the final beat is accepted together with a new start, which chains the next packet with no gap.

Top module: `pkt_stream_src`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `m_tvalid` is low.
- R2: In a cycle with `m_tvalid` high and `m_tready` low, the next cycle shows `m_tvalid` high with `m_tdata` and `m_tlast` unchanged.
- R3: A packet consists of exactly N accepted beats, where N is its length, and `m_tlast` is high on the N-th beat only, even if the sink stalls on beat N-1. `m_tvalid` stays high from the first beat to the last.
- R4: Whenever `m_tvalid` is high, `m_tdata` equals the number of beats accepted since reset, modulo 2^DATA_W. The first beat after reset carries 0.
- R5: The length is captured in the cycle the start is taken. Later values of `len_i` do not alter the packet.
- R6: A length of 1 yields a single beat with `m_tlast` high.
- R7: A start raised while a packet is still in progress has no effect, unless it coincides with acceptance of that packet's final beat.
- R8: A start with nonzero length in the cycle the final beat is accepted makes the next cycle offer beat 1 of the new packet, with `m_tvalid` still high.
- R9: After the final beat is accepted with no start taken, `m_tvalid` is low in the next cycle.
- R10: A start with `len_i` equal to 0 is ignored, and `m_tvalid` stays low.
- R11: When idle, a start with nonzero length makes `m_tvalid` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a packet |
| len_i | input | LEN_W | Beat count for the requested packet |
| m_tvalid | output | 1 | Beat offered to the sink |
| m_tready | input | 1 | Sink accepts the offered beat |
| m_tdata | output | DATA_W | Beat payload (running accepted-beat count) |
| m_tlast | output | 1 | Final beat of the packet |

## Verification
Several rules are checked on every cycle against small independent models of the channel:

- reset clearing of `m_tvalid`;
- the hold-under-stall rule;
- payload equal to the accepted-beat count;
- end-marker placement against the captured length;
- the idle, drop and chain behaviour around packet ends.

Some behaviours only show up in the bench's scenarios:

- that later `len_i` values are ignored after capture;
- that mid-packet starts do nothing;
- the exact beat count under varied ready patterns;
- a stall held on the next-to-last beat;
- recovery from reset in the middle of a packet.

// File: rtl/pkt_src_pkg.sv
package pkt_src_pkg;

    // Sequencer states: nothing offered, non-final beat offered, final beat offered
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_LAST   = 2'd2
    } pkt_state_e;

endpackage

// File: rtl/pkt_src_fsm.sv
module pkt_src_fsm
    import pkt_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,   // start with a nonzero length
    input  logic       fire,        // beat accepted this cycle
    input  logic       can_load,    // output slot may be reloaded
    input  logic       last_next,   // beat about to be loaded is final
    output logic       take,        // start accepted this cycle
    output logic       next_valid,  // a beat should be loaded
    output pkt_state_e state_o
);

    pkt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Start acceptance: idle, or the final beat is leaving right now
    always_comb begin
        take = 1'b0;
        unique case (state_q)
            ST_IDLE:   take = start_req;
            ST_STREAM: take = 1'b0;
            ST_LAST:   take = start_req & fire;
            default:   take = 1'b0;
        endcase
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = last_next ? ST_LAST : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (can_load) begin
                    state_d = last_next ? ST_LAST : ST_STREAM;
                end
            end
            ST_LAST: begin
                if (fire) begin
                    if (take) begin
                        state_d = last_next ? ST_LAST : ST_STREAM;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        next_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   next_valid = take;
            ST_STREAM: next_valid = 1'b1;
            ST_LAST:   next_valid = take;
            default:   next_valid = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pkt_src_track.sv
module pkt_src_track #(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              fire,
    input  logic [LEN_W-1:0]  len_i,
    output logic              last_next,
    output logic [DATA_W-1:0] data_next
);

    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    logic [LEN_W-1:0]  len_q;    // captured packet length
    logic [LEN_W-1:0]  acc_q;    // beats accepted in current packet
    logic [DATA_W-1:0] tot_q;    // beats accepted since reset

    logic [LEN_W-1:0]  idx_next;
    logic [LEN_W-1:0]  len_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            len_q <= len_i;
            acc_q <= '0;
        end else if (fire) begin
            acc_q <= acc_q + ONE_L;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
        end else if (fire) begin
            tot_q <= tot_q + DATA_W'(1);
        end
    end

    // Position of the beat that would be loaded now, from accepted beats only
    always_comb begin
        idx_next  = take ? '0 : (acc_q + LEN_W'(fire));
        len_eff   = take ? len_i : len_q;
        last_next = (idx_next == (len_eff - ONE_L));
        data_next = tot_q + DATA_W'(fire);
    end

endmodule

// File: rtl/pkt_src_axis_reg.sv
module pkt_src_axis_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_tready,
    input  logic              next_valid,
    input  logic [DATA_W-1:0] next_data,
    input  logic              next_last,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast
);

    // Sole update path for the channel: only when empty or being taken
    always_ff @(posedge clk) begin
        if (rst) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tlast  <= 1'b0;
        end else if (!m_tvalid || m_tready) begin
            m_tvalid <= next_valid;
            m_tdata  <= next_data;
            m_tlast  <= next_valid & next_last;
        end
    end

endmodule

// File: rtl/pkt_stream_src.sv
module pkt_stream_src
    import pkt_src_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast
);

    logic              fire;
    logic              can_load;
    logic              start_req;
    logic              take;
    logic              next_valid;
    logic              last_next;
    logic [DATA_W-1:0] data_next;
    pkt_state_e        state;

    assign fire      = m_tvalid & m_tready;
    assign can_load  = ~m_tvalid | m_tready;
    assign start_req = start_i & (len_i != '0);

    pkt_src_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .fire       (fire),
        .can_load   (can_load),
        .last_next  (last_next),
        .take       (take),
        .next_valid (next_valid),
        .state_o    (state)
    );

    pkt_src_track #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .fire      (fire),
        .len_i     (len_i),
        .last_next (last_next),
        .data_next (data_next)
    );

    pkt_src_axis_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .m_tready   (m_tready),
        .next_valid (next_valid),
        .next_data  (data_next),
        .next_last  (last_next),
        .m_tvalid   (m_tvalid),
        .m_tdata    (m_tdata),
        .m_tlast    (m_tlast)
    );

    logic unused_state;
    assign unused_state = ^state;

endmodule

// File: rtl/pkt_stream_src_chk.sv
module pkt_stream_src_chk #(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tlast
);

    logic              armed = 1'b0;
    logic              rst_d = 1'b0;
    logic [DATA_W-1:0] beats_q;
    logic [LEN_W-1:0]  exp_len;
    logic [LEN_W-1:0]  pk_cnt;
    logic              fire_m;
    logic              take_m;
    logic              start_ok;

    assign fire_m   = m_tvalid & m_tready;
    assign start_ok = start_i & (len_i != '0);
    assign take_m   = start_ok & (!m_tvalid | (fire_m & m_tlast));

    always_ff @(posedge clk) begin
        rst_d <= rst;
        armed <= !rst;
    end

    // Independent reference counters
    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
            exp_len <= '0;
            pk_cnt  <= '0;
        end else begin
            if (fire_m) beats_q <= beats_q + DATA_W'(1);
            if (take_m) begin
                exp_len <= len_i;
                pk_cnt  <= '0;
            end else if (fire_m) begin
                pk_cnt <= pk_cnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_reset_clears_R1: assert (!m_tvalid);
        end
    end

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    assert_last_position_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && m_tvalid) |-> (m_tlast == (pk_cnt == (exp_len - LEN_W'(1)))));

    assert_payload_count_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && m_tvalid) |-> (m_tdata == beats_q));

    assert_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && fire_m && m_tlast && start_ok) |=> m_tvalid);

    assert_drop_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && fire_m && m_tlast && !start_ok) |=> !m_tvalid);

    assert_idle_stays_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && !m_tvalid && !start_ok) |=> !m_tvalid);

    assert_start_offers_R11: assert property (@(posedge clk) disable iff (rst)
        (armed && !m_tvalid && start_ok) |=> m_tvalid);

endmodule

bind pkt_stream_src pkt_stream_src_chk #(
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .len_i    (len_i),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
);

// File: tb/pkt_stream_src_tb.sv
module pkt_stream_src_tb;

    localparam int LEN_W  = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 6;

    // {length, ready pattern}; bit c%8 of the pattern drives m_tready
    localparam logic [15:0] VECS [0:NVEC-1] = '{
        16'h01_FF, 16'h05_FF, 16'h03_55, 16'h06_B6, 16'h01_6D, 16'h08_E7
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  len_i = '0;
    logic              m_tready = 1'b0;
    logic              m_tvalid;
    logic [DATA_W-1:0] m_tdata;
    logic              m_tlast;

    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;
    logic [DATA_W-1:0] exp_data = '0;

    always #4 clk = ~clk;

    pkt_stream_src #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .len_i    (len_i),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tdata  (m_tdata),
        .m_tlast  (m_tlast)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Issue a start from idle; returns at the negedge where the first beat is offered
    task automatic launch(input int len);
        @(negedge clk);
        start_i  = 1'b1;
        len_i    = LEN_W'(len);
        m_tready = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        len_i   = 8'hAA;   // R5: later length values must not matter
        chk(m_tvalid == 1'b1, "R11", m_tvalid, 1);
    endtask

    // Consume beats first..len-1 under a ready pattern, then check the drop
    task automatic drain(input int len, input int first, input logic [7:0] pat, input string tag);
        int   beat = first;
        int   c = 0;
        bit   pv = 1'b0;
        logic [DATA_W-1:0] pd = '0;
        logic pl = 1'b0;
        while (beat < len && c < 400) begin
            if (pv) begin
                chk(m_tvalid && m_tdata == pd && m_tlast == pl, "R2", m_tdata, pd);
            end
            chk(m_tvalid == 1'b1, "R3", m_tvalid, 1);
            m_tready = pat[c%8];
            if (m_tvalid && m_tready) begin
                chk(m_tdata == exp_data, "R4", m_tdata, exp_data);
                chk(m_tlast == (beat == len - 1), tag, m_tlast, (beat == len - 1));
                beat++;
                exp_data++;
                pv = 1'b0;
            end else begin
                pv = m_tvalid;
            end
            pd = m_tdata;
            pl = m_tlast;
            c++;
            @(negedge clk);
        end
        m_tready = 1'b0;
        chk(beat == len, tag, beat, len);
        chk(m_tvalid == 1'b0, "R9", m_tvalid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", m_tvalid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", m_tvalid, 0);

        // Vector table: lengths and ready patterns (R3, R4, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            launch(int'(VECS[i][15:8]));
            drain(int'(VECS[i][15:8]), 0, VECS[i][7:0], (VECS[i][15:8] == 8'd1) ? "R6" : "R3");
        end

        // R10: zero length ignored
        @(negedge clk);
        start_i = 1'b1;
        len_i   = '0;
        @(negedge clk);
        start_i = 1'b0;
        chk(m_tvalid == 1'b0, "R10", m_tvalid, 0);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", m_tvalid, 0);

        // R3: stall held on the next-to-last beat
        launch(3);
        m_tready = 1'b1;
        chk(m_tdata == exp_data, "R4", m_tdata, exp_data);
        exp_data++;
        @(negedge clk);
        m_tready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(m_tvalid && !m_tlast, "R3", m_tlast, 0);
            @(negedge clk);
        end
        drain(3, 1, 8'hFF, "R3");

        // R7: start during a packet has no effect
        launch(4);
        start_i = 1'b1;
        len_i   = 8'd9;
        @(negedge clk);
        @(negedge clk);
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
        start_i  = 1'b0;
        exp_data++;
        drain(4, 1, 8'hFF, "R7");

        // R8: back-to-back chaining on the final beat
        launch(2);
        m_tready = 1'b1;
        chk(m_tdata == exp_data, "R4", m_tdata, exp_data);
        exp_data++;
        @(negedge clk);
        chk(m_tlast == 1'b1, "R3", m_tlast, 1);
        start_i = 1'b1;
        len_i   = 8'd3;
        exp_data++;
        @(negedge clk);
        start_i  = 1'b0;
        len_i    = 8'd1;
        m_tready = 1'b0;
        chk(m_tvalid == 1'b1, "R8", m_tvalid, 1);
        chk(m_tlast == 1'b0, "R8", m_tlast, 0);
        drain(3, 0, 8'hFF, "R8");

        // R1: reset in the middle of a packet
        launch(5);
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", m_tvalid, 0);
        rst = 1'b0;
        exp_data = '0;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", m_tvalid, 0);
        launch(2);
        drain(2, 0, 8'hFF, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule